// File: doc/BRIEF.md
# Segmented DAC Code Controller

This block turns one channel's 16-bit two's complement audio sample into the digital controls of a three-stage segmented converter. The sample is first moved to offset binary by inverting its sign bit. The top nine bits then pick a position on a 512-step resistor string. The middle three bits drive a pulse-width signal that switches the output between the lower and the upper of the two neighbouring string taps, which splits that interval into eight steps. The bottom four bits set a complementary pair of trim-resistor codes whose sum never changes.

Pulse timing comes from one of two tick-enable inputs. One follows the bit clock and the other follows the system clock, and a select input picks between them. A sample loaded with the strobe waits in a holding register and takes effect only where a PWM period ends, so no partial pulse is ever produced. A stereo design uses two instances fed from the same ticks, which keeps the two channels in phase.

Top module: `segm_dac_ctrl`

## Requirements
- R1: After reset, and until a loaded sample is applied, the outputs match sample zero: tap_idx = 256, use_upper = 0, trim_lo = 0 and trim_hi = 15.
- R2: tap_idx equals bits 15..7 of the applied sample with bit 15 inverted. Sample 0x8000 gives tap 0, 0x7FFF gives tap 511 and 0x0000 gives tap 256.
- R3: trim_lo equals bits 3..0 of the applied sample and trim_hi equals 15 minus those bits, so trim_lo + trim_hi = 15 at all times.
- R4: A PWM period is 8 selected ticks. With N = bits 6..4 of the applied sample, use_upper is high during the first N ticks of each period and low for the rest. N = 0 keeps it low for the whole period.
- R5: With tb_sel = 0 only tick_bit advances the PWM time base. With tb_sel = 1 only tick_sys advances it. Pulses on the input that is not selected have no effect.
- R6: A loaded sample takes effect on the clock edge of the 8th selected tick of the current period. Until that edge, every output keeps the previous sample's value.
- R7: If several samples are loaded within one period, the last one loaded is the one applied.
- R8: When no selected tick occurs, all outputs hold their values, even when load pulses arrive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample | input | 16 | Two's complement sample word |
| load | input | 1 | Captures `sample` into the holding register |
| tick_bit | input | 1 | One-cycle enable derived from the bit clock |
| tick_sys | input | 1 | One-cycle enable derived from the system clock |
| tb_sel | input | 1 | PWM time base select: 0 = tick_bit, 1 = tick_sys |
| tap_idx | output | 9 | Resistor-string tap index (lower tap) |
| use_upper | output | 1 | PWM signal: 1 selects the upper of the two taps |
| trim_lo | output | 4 | Code of the trim resistor at the low string end |
| trim_hi | output | 4 | Code of the trim resistor at the high string end |

## Verification
A wrong period counter shows up as a wrong count of high use_upper ticks, or as high ticks out of place, within one period of 8 selected ticks. A wrong holding or apply path shows up as tap and trim values that change too early, too late or to the wrong sample. That error appears at the period boundary, one clock after the 8th tick. A wrong sign conversion or field split shows up on the outputs as soon as the sample is applied. The stimulus is chosen to expose it: sign-boundary codes, all-ones and all-zeros fields, and mixed patterns.

// File: rtl/segm_pkg.sv
package segm_pkg;
   localparam int DEF_SAMPLE_W = 16;
   localparam int DEF_TAP_W    = 9;
   localparam int DEF_PWM_W    = 3;
   localparam int DEF_TRIM_W   = 4;

   typedef enum logic {
      TB_BIT = 1'b0,
      TB_SYS = 1'b1
   } timebase_e;
endpackage

// File: rtl/segm_split.sv
module segm_split #(
   parameter int SAMPLE_W   = segm_pkg::DEF_SAMPLE_W,
   parameter int TAP_W      = segm_pkg::DEF_TAP_W,
   parameter int PWM_W      = segm_pkg::DEF_PWM_W,
   parameter int TRIM_W     = segm_pkg::DEF_TRIM_W,
   parameter bit OFFSET_BIN = 1'b1
) (
   input  logic [SAMPLE_W-1:0] code,
   output logic [TAP_W-1:0]    tap,
   output logic [PWM_W-1:0]    mid,
   output logic [TRIM_W-1:0]   low
);
   localparam int TAP_LSB = PWM_W + TRIM_W;

   logic [SAMPLE_W-1:0] ubin;

   initial begin
      if (TAP_W + PWM_W + TRIM_W != SAMPLE_W)
         $error("segm_split: field widths must sum to SAMPLE_W");
   end

   generate
      if (OFFSET_BIN) begin : g_offset
         assign ubin = {~code[SAMPLE_W-1], code[SAMPLE_W-2:0]};
      end else begin : g_raw
         assign ubin = code;
      end
   endgenerate

   assign tap = ubin[SAMPLE_W-1:TAP_LSB];
   assign mid = ubin[TAP_LSB-1:TRIM_W];
   assign low = ubin[TRIM_W-1:0];
endmodule

// File: rtl/segm_timebase.sv
module segm_timebase #(
   parameter int PWM_W = segm_pkg::DEF_PWM_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_bit,
   input  logic             tick_sys,
   input  logic             tb_sel,
   output logic             tick,
   output logic [PWM_W-1:0] cnt,
   output logic             wrap
);
   import segm_pkg::*;

   localparam logic [PWM_W-1:0] CNT_LAST = {PWM_W{1'b1}};

   timebase_e src;

   initial begin
      if (PWM_W < 1) $error("segm_timebase: PWM_W must be at least 1");
   end

   assign src  = timebase_e'(tb_sel);
   assign tick = (src == TB_SYS) ? tick_sys : tick_bit;
   assign wrap = tick && (cnt == CNT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/segm_trim.sv
module segm_trim #(
   parameter int TRIM_W = segm_pkg::DEF_TRIM_W
) (
   input  logic [TRIM_W-1:0] low,
   output logic [TRIM_W-1:0] lo_code,
   output logic [TRIM_W-1:0] hi_code
);
   localparam logic [TRIM_W-1:0] TRIM_MAX = {TRIM_W{1'b1}};

   initial begin
      if (TRIM_W < 1) $error("segm_trim: TRIM_W must be at least 1");
   end

   assign lo_code = low;
   assign hi_code = TRIM_MAX - low;
endmodule

// File: rtl/segm_dac_ctrl.sv
module segm_dac_ctrl #(
   parameter int SAMPLE_W   = segm_pkg::DEF_SAMPLE_W,
   parameter int TAP_W      = segm_pkg::DEF_TAP_W,
   parameter int PWM_W      = segm_pkg::DEF_PWM_W,
   parameter int TRIM_W     = segm_pkg::DEF_TRIM_W,
   parameter bit OFFSET_BIN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SAMPLE_W-1:0] sample,
   input  logic                load,
   input  logic                tick_bit,
   input  logic                tick_sys,
   input  logic                tb_sel,
   output logic [TAP_W-1:0]    tap_idx,
   output logic                use_upper,
   output logic [TRIM_W-1:0]   trim_lo,
   output logic [TRIM_W-1:0]   trim_hi
);
   logic [SAMPLE_W-1:0] pend_q, act_q, pend_nxt;
   logic                pend_v;
   logic                tick, wrap;
   logic [PWM_W-1:0]    cnt;
   logic [PWM_W-1:0]    act_mid;
   logic [TRIM_W-1:0]   act_low;

   initial begin
      if (TAP_W + PWM_W + TRIM_W != SAMPLE_W)
         $error("segm_dac_ctrl: field widths must sum to SAMPLE_W");
   end

   assign pend_nxt = load ? sample : pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         pend_v <= 1'b0;
         act_q  <= '0;
      end else begin
         if (wrap && (load || pend_v)) begin
            act_q  <= pend_nxt;
            pend_v <= 1'b0;
         end else if (load) begin
            pend_v <= 1'b1;
         end
         if (load) pend_q <= sample;
      end
   end

   segm_timebase #(.PWM_W(PWM_W)) u_timebase (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_bit (tick_bit),
      .tick_sys (tick_sys),
      .tb_sel   (tb_sel),
      .tick     (tick),
      .cnt      (cnt),
      .wrap     (wrap)
   );

   segm_split #(
      .SAMPLE_W   (SAMPLE_W),
      .TAP_W      (TAP_W),
      .PWM_W      (PWM_W),
      .TRIM_W     (TRIM_W),
      .OFFSET_BIN (OFFSET_BIN)
   ) u_split (
      .code (act_q),
      .tap  (tap_idx),
      .mid  (act_mid),
      .low  (act_low)
   );

   segm_trim #(.TRIM_W(TRIM_W)) u_trim (
      .low     (act_low),
      .lo_code (trim_lo),
      .hi_code (trim_hi)
   );

   assign use_upper = (cnt < act_mid);
endmodule

// File: rtl/segm_dac_ctrl_chk.sv
module segm_dac_ctrl_chk #(
   parameter int TAP_W  = segm_pkg::DEF_TAP_W,
   parameter int PWM_W  = segm_pkg::DEF_PWM_W,
   parameter int TRIM_W = segm_pkg::DEF_TRIM_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_bit,
   input logic              tick_sys,
   input logic              tb_sel,
   input logic [TAP_W-1:0]  tap_idx,
   input logic              use_upper,
   input logic [TRIM_W-1:0] trim_lo,
   input logic [TRIM_W-1:0] trim_hi,
   input logic [PWM_W-1:0]  cnt
);
   localparam logic [PWM_W-1:0]  LAST = {PWM_W{1'b1}};
   localparam logic [TRIM_W:0]   TSUM = {1'b0, {TRIM_W{1'b1}}};

   logic stick;
   assign stick = tb_sel ? tick_sys : tick_bit;

   p_trim_sum_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, trim_lo} + {1'b0, trim_hi}) == TSUM);

   p_hold_no_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !stick |=> ($stable(tap_idx) && $stable(trim_lo) && $stable(use_upper)));

   p_apply_at_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(stick && cnt == LAST) |=> ($stable(tap_idx) && $stable(trim_hi)));

   p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      stick |=> (cnt == $past(cnt) + 1'b1));

   p_pwm_low_stays_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (stick && !use_upper && cnt != LAST) |=> !use_upper);
endmodule

bind segm_dac_ctrl segm_dac_ctrl_chk #(
   .TAP_W  (TAP_W),
   .PWM_W  (PWM_W),
   .TRIM_W (TRIM_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_bit  (tick_bit),
   .tick_sys  (tick_sys),
   .tb_sel    (tb_sel),
   .tap_idx   (tap_idx),
   .use_upper (use_upper),
   .trim_lo   (trim_lo),
   .trim_hi   (trim_hi),
   .cnt       (cnt)
);

// File: tb/segm_dac_ctrl_bench.sv
module segm_dac_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] sample = '0;
   logic        load = 1'b0;
   logic        tick_bit = 1'b0;
   logic        tick_sys = 1'b0;
   logic        tb_sel = 1'b0;
   logic [8:0]  tap_idx;
   logic        use_upper;
   logic [3:0]  trim_lo;
   logic [3:0]  trim_hi;

   int checks = 0;
   int errors = 0;
   int ph = 0;
   bit done = 1'b0;

   // {sample, expected tap, expected N, expected trim_lo}
   localparam int NV = 9;
   localparam logic [31:0] VEC [NV] = '{
      {16'h0000, 9'h100, 3'd0, 4'd0},
      {16'h8000, 9'h000, 3'd0, 4'd0},
      {16'h7FFF, 9'h1FF, 3'd7, 4'd15},
      {16'hFFFF, 9'h0FF, 3'd7, 4'd15},
      {16'h0123, 9'h102, 3'd2, 4'd3},
      {16'hA5C3, 9'h04B, 3'd4, 4'd3},
      {16'h5A3C, 9'h1B4, 3'd3, 4'd12},
      {16'h0070, 9'h100, 3'd7, 4'd0},
      {16'h0010, 9'h100, 3'd1, 4'd0}
   };

   always #5 clk = ~clk;

   segm_dac_ctrl u_segm_dac_ctrl (
      .clk(clk), .rst_n(rst_n), .sample(sample), .load(load),
      .tick_bit(tick_bit), .tick_sys(tick_sys), .tb_sel(tb_sel),
      .tap_idx(tap_idx), .use_upper(use_upper),
      .trim_lo(trim_lo), .trim_hi(trim_hi)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic ticks(input int k);
      for (int i = 0; i < k; i++) begin
         if (tb_sel) tick_sys = 1'b1; else tick_bit = 1'b1;
         step();
         tick_sys = 1'b0;
         tick_bit = 1'b0;
         ph = (ph + 1) % 8;
      end
   endtask

   task automatic load_word(input logic [15:0] s);
      sample = s;
      load = 1'b1;
      step();
      load = 1'b0;
   endtask

   task automatic apply(input logic [15:0] s);
      load_word(s);
      ticks(8 - ph);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #2;
      check("R1 tap in reset", 32'(tap_idx), 32'd256);
      repeat (3) step();
      rst_n = 1'b1;
      step();
      check("R1 tap", 32'(tap_idx), 32'd256);
      check("R1 use_upper", 32'(use_upper), 32'd0);
      check("R1 trim_lo", 32'(trim_lo), 32'd0);
      check("R1 trim_hi", 32'(trim_hi), 32'd15);

      // table walk: R2, R3, R4 with both time bases
      for (int v = 0; v < NV; v++) begin
         logic [15:0] s;
         logic [8:0]  et;
         logic [2:0]  en;
         logic [3:0]  el;
         {s, et, en, el} = VEC[v];
         tb_sel = v[0];
         apply(s);
         check("R2 tap", 32'(tap_idx), 32'(et));
         check("R3 trim_lo", 32'(trim_lo), 32'(el));
         check("R3 trim_hi", 32'(trim_hi), 32'(4'd15 - el));
         for (int i = 0; i < 8; i++) begin
            check("R4 pwm shape", 32'(use_upper), 32'(i < int'(en)));
            ticks(1);
         end
      end
      tb_sel = 1'b0;

      // R7: last load in a period wins
      load_word(16'h8000);
      load_word(16'h7FFF);
      ticks(8 - ph);
      check("R7 last load applied", 32'(tap_idx), 32'd511);

      // R6: deferred until period end
      load_word(16'h0000);
      ticks(7);
      check("R6 held before boundary", 32'(tap_idx), 32'd511);
      check("R6 trim held", 32'(trim_lo), 32'd15);
      ticks(1);
      check("R6 applied at boundary", 32'(tap_idx), 32'd256);
      check("R6 trim applied", 32'(trim_hi), 32'd15);

      // R5: unselected tick ignored
      apply(16'h0040);
      check("R5 start high", 32'(use_upper), 32'd1);
      tb_sel = 1'b1;
      for (int i = 0; i < 6; i++) begin
         tick_bit = 1'b1;
         step();
      end
      tick_bit = 1'b0;
      check("R5 unselected tick ignored", 32'(use_upper), 32'd1);
      ticks(4);
      check("R5 selected tick counts", 32'(use_upper), 32'd0);
      ticks(8 - ph);
      check("R5 new period high", 32'(use_upper), 32'd1);

      // R8: no ticks, outputs frozen even with loads
      load_word(16'h5A3C);
      repeat (20) step();
      load_word(16'hFFFF);
      check("R8 tap frozen", 32'(tap_idx), 32'd256);
      check("R8 use_upper frozen", 32'(use_upper), 32'd1);
      ticks(8 - ph);
      check("R7 latest after freeze", 32'(tap_idx), 32'd255);

      // R1: reset mid operation
      load_word(16'h7FFF);
      rst_n = 1'b0;
      step();
      rst_n = 1'b1;
      ph = 0;
      step();
      ticks(8);
      check("R1 after reset tap", 32'(tap_idx), 32'd256);
      check("R1 after reset trim_hi", 32'(trim_hi), 32'd15);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule